// File: doc/BRIEF.md
# Indirect Program Memory Access Unit

This unit gives a processor core table-style access to its program memory through a 17-bit byte address register and two 8-bit data registers. The core fills the address and data bytes over a small register port. It then pulses one of four operation strobes: read, read with post-increment, write, or write with post-increment. The unit drops the always-zero address LSB to form the 16-bit word address for memory. It classifies the address as program RAM, reserved space or flash, and runs one request on a simple request/ready memory port.

A read splits the returned word across the two data bytes. A write sends the two data bytes as one word and is allowed only into program RAM. The unit refuses three kinds of operation: any access with a misaligned address, any access to reserved space, and any write outside program RAM. A refused operation never reaches memory and sets a sticky error flag. Its post-increment still takes effect, so a table walk keeps its pace.

Top module: `ipm_access`

## Requirements
- R1: After reset the address and both data bytes read as zero, error and busy are 0, and `mem_req_o` is 0.
- R2: A register write with `reg_sel_i` set to 0, 1 or 2 loads address bits 7:0, 15:8 or 16 (bit 0 of the data byte). A write with select 3 or 4 loads the low or high data byte. Reading a select returns the same field, zero-extended to 8 bits.
- R3: `op_i` 0 is a read and 1 is a read with increment. A read issues `mem_addr_o` equal to the byte address shifted right by one, with `mem_we_o` low. On completion, word bits 15:8 go to the high data byte and bits 7:0 go to the low data byte. The data bytes change only when a read completes or the core writes them.
- R4: `op_i` 2 is a write and 3 is a write with increment. A write issues `mem_we_o` high with `mem_wdata_o` equal to {high byte, low byte}. A write reaches memory only when the address lies in program RAM.
- R5: The increment variants add 2 to the 17-bit address when the operation completes. The carry crosses all three address bytes, and 0x1FFFE wraps to 0x00000.
- R6: `mem_region_o` is 0 (program RAM) for byte addresses below 0x04000, 2 (reserved) for 0x04000–0x0FFFF, and 1 (flash) for 0x10000 and above.
- R7: An operation is refused if its address has bit 0 set, lies in reserved space, or is a write outside program RAM. A refused operation issues no memory request, leaves the data bytes unchanged and sets the error flag. An increment variant still advances the address by 2.
- R8: An accepted strobe raises `busy_o` and `mem_req_o` on the next edge. Both stay high, with address, write flag and write data held, until the edge on which `mem_ready_i` is sampled high. Strobes and register writes that arrive while busy are ignored.
- R9: The error flag stays set until a register write with select 5. A read of select 5 returns {6'b0, busy, error}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write enable |
| reg_sel_i | input | 3 | Register select (0 addr lo, 1 addr hi, 2 addr ext, 3 data lo, 4 data hi, 5 status) |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_sel_i` |
| op_valid_i | input | 1 | Operation strobe |
| op_i | input | 2 | Operation code |
| busy_o | output | 1 | Operation in progress |
| err_o | output | 1 | Sticky error flag |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_region_o | output | 2 | Region of the current address |
| mem_addr_o | output | 16 | Word address |
| mem_wdata_o | output | 16 | Write word |
| mem_rdata_i | input | 16 | Read word |
| mem_ready_i | input | 1 | Memory completes the request |

## Verification
On every cycle, the assertions check four things. A write request never targets anything but program RAM, and no request enters reserved space. A pending request holds its address, data and direction until ready, and busy drops right after ready. The address steps by exactly two on each advance, and the error flag never clears without the clear write. The bench scenarios alone can show other properties. Read data lands in the right byte halves, and writes hit the right RAM words, which later reads confirm. Refused operations still advance the address. Carries cross byte boundaries, 0x1FFFE wraps to zero, and traffic on the register port during a wait is dropped.

// File: rtl/ipm_pkg.sv
package ipm_pkg;
  typedef enum logic [1:0] {
    OP_RD  = 2'b00,
    OP_RDI = 2'b01,
    OP_WR  = 2'b10,
    OP_WRI = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    RGN_RAM   = 2'b00,
    RGN_FLASH = 2'b01,
    RGN_RSVD  = 2'b10
  } rgn_e;

  typedef enum logic [2:0] {
    SEL_ADDR_LO = 3'd0,
    SEL_ADDR_HI = 3'd1,
    SEL_ADDR_EX = 3'd2,
    SEL_DATA_LO = 3'd3,
    SEL_DATA_HI = 3'd4,
    SEL_STATUS  = 3'd5
  } sel_e;
endpackage

// File: rtl/ipm_region_dec.sv
module ipm_region_dec
  import ipm_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int RAM_BYTES  = 'h04000,
  parameter int FLASH_BASE = 'h10000
) (
  input  logic [ADDR_W-1:0] addr_i,
  output rgn_e              rgn_o
);
  localparam logic [ADDR_W-1:0] RamLim   = ADDR_W'(RAM_BYTES);
  localparam logic [ADDR_W-1:0] FlashLim = ADDR_W'(FLASH_BASE);

  always_comb begin
    if (addr_i < RamLim)        rgn_o = RGN_RAM;
    else if (addr_i >= FlashLim) rgn_o = RGN_FLASH;
    else                         rgn_o = RGN_RSVD;
  end
endmodule

// File: rtl/ipm_addr_reg.sv
module ipm_addr_reg #(
  parameter int ADDR_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        wr_en_i,
  input  logic [7:0]        wdata_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int ExtW = ADDR_W - 16;

  logic [ADDR_W-1:0] addr_q;

  // advance has priority over a same-cycle byte write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (inc_i) begin
      addr_q <= addr_q + ADDR_W'(2);
    end else begin
      if (wr_en_i[0]) addr_q[7:0]         <= wdata_i;
      if (wr_en_i[1]) addr_q[15:8]        <= wdata_i;
      if (wr_en_i[2]) addr_q[ADDR_W-1:16] <= wdata_i[ExtW-1:0];
    end
  end

  assign addr_o = addr_q;

  a_r5_step_two: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |=> addr_q == $past(addr_q) + ADDR_W'(2));
endmodule

// File: rtl/ipm_ctrl.sv
module ipm_ctrl
  import ipm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       op_valid_i,
  input  logic [1:0] op_i,
  input  rgn_e       rgn_i,
  input  logic       lsb_i,
  input  logic       mem_ready_i,
  input  logic       clr_i,
  output logic       busy_o,
  output logic       we_o,
  output logic       inc_o,
  output logic       load_o,
  output logic       err_o
);
  logic       busy_q, err_q;
  logic [1:0] op_q;
  logic       accept, refuse, done;

  assign accept = op_valid_i & ~busy_q;
  assign refuse = lsb_i | (rgn_i == RGN_RSVD) | (op_i[1] & (rgn_i != RGN_RAM));
  assign done   = busy_q & mem_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      op_q   <= OP_RD;
      err_q  <= 1'b0;
    end else begin
      if (accept && !refuse) begin
        busy_q <= 1'b1;
        op_q   <= op_i;
      end else if (done) begin
        busy_q <= 1'b0;
      end
      if (accept && refuse) err_q <= 1'b1;
      else if (clr_i)       err_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign we_o   = op_q[1];
  assign inc_o  = (accept & refuse & op_i[0]) | (done & op_q[0]);
  assign load_o = done & ~op_q[1];
  assign err_o  = err_q;

  a_r8_done_drops_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && mem_ready_i |=> !busy_q);
  a_r8_wait_holds_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !mem_ready_i |=> busy_q && $stable(op_q));
  a_r7_refuse_no_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && refuse |=> !busy_q && err_q);
  a_r9_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q && !clr_i |=> err_q);
endmodule

// File: rtl/ipm_access.sv
module ipm_access
  import ipm_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 16,
  parameter int RAM_BYTES  = 'h04000,
  parameter int FLASH_BASE = 'h10000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_sel_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              op_valid_i,
  input  logic [1:0]        op_i,
  output logic              busy_o,
  output logic              err_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [1:0]        mem_region_o,
  output logic [ADDR_W-2:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ready_i
);
  localparam int HalfW = DATA_W / 2;
  localparam int ExtW  = ADDR_W - 16;

  logic [ADDR_W-1:0] addr;
  rgn_e              rgn;
  logic              busy, err, we, inc, load, cpu_we;
  logic [2:0]        addr_wr;
  logic [HalfW-1:0]  data_lo_q, data_hi_q;
  sel_e              sel;

  assign sel    = sel_e'(reg_sel_i);
  assign cpu_we = reg_we_i & ~busy;

  always_comb begin
    addr_wr = '0;
    case (sel)
      SEL_ADDR_LO: addr_wr[0] = cpu_we;
      SEL_ADDR_HI: addr_wr[1] = cpu_we;
      SEL_ADDR_EX: addr_wr[2] = cpu_we;
      default:     addr_wr    = '0;
    endcase
  end

  ipm_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (addr_wr),
    .wdata_i (reg_wdata_i),
    .inc_i   (inc),
    .addr_o  (addr)
  );

  ipm_region_dec #(
    .ADDR_W     (ADDR_W),
    .RAM_BYTES  (RAM_BYTES),
    .FLASH_BASE (FLASH_BASE)
  ) u_dec (
    .addr_i (addr),
    .rgn_o  (rgn)
  );

  ipm_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .op_valid_i  (op_valid_i),
    .op_i        (op_i),
    .rgn_i       (rgn),
    .lsb_i       (addr[0]),
    .mem_ready_i (mem_ready_i),
    .clr_i       (cpu_we && sel == SEL_STATUS),
    .busy_o      (busy),
    .we_o        (we),
    .inc_o       (inc),
    .load_o      (load),
    .err_o       (err)
  );

  // completed read beats a same-cycle core write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_lo_q <= '0;
      data_hi_q <= '0;
    end else if (load) begin
      data_lo_q <= mem_rdata_i[HalfW-1:0];
      data_hi_q <= mem_rdata_i[DATA_W-1:HalfW];
    end else if (cpu_we) begin
      if (sel == SEL_DATA_LO) data_lo_q <= reg_wdata_i;
      if (sel == SEL_DATA_HI) data_hi_q <= reg_wdata_i;
    end
  end

  always_comb begin
    case (sel)
      SEL_ADDR_LO: reg_rdata_o = addr[7:0];
      SEL_ADDR_HI: reg_rdata_o = addr[15:8];
      SEL_ADDR_EX: reg_rdata_o = 8'(addr[ADDR_W-1:16]);
      SEL_DATA_LO: reg_rdata_o = data_lo_q;
      SEL_DATA_HI: reg_rdata_o = data_hi_q;
      SEL_STATUS:  reg_rdata_o = {6'b0, busy, err};
      default:     reg_rdata_o = '0;
    endcase
  end

  assign busy_o       = busy;
  assign err_o        = err;
  assign mem_req_o    = busy;
  assign mem_we_o     = we;
  assign mem_region_o = rgn;
  assign mem_addr_o   = addr[ADDR_W-1:1];
  assign mem_wdata_o  = {data_hi_q, data_lo_q};

  a_r4_write_ram_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> mem_region_o == RGN_RAM);
  a_r7_no_rsvd_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_region_o != RGN_RSVD);
  a_r8_req_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o)
      && $stable(mem_wdata_o) && $stable(mem_we_o));
  a_r3_data_hold_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && !mem_ready_i |=> $stable(data_lo_q) && $stable(data_hi_q));
  a_r2_ext_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ExtW >= 1 && ExtW <= 8);
endmodule

// File: tb/sim_ipm_access.sv
`timescale 1ns/1ps
module sim_ipm_access;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_sel_i = '0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic        op_valid_i = 1'b0;
  logic [1:0]  op_i = '0;
  logic        busy_o, err_o, mem_req_o, mem_we_o;
  logic [1:0]  mem_region_o;
  logic [15:0] mem_addr_o, mem_wdata_o;
  logic [15:0] mem_rdata_i = '0;
  logic        mem_ready_i = 1'b0;

  always #2 clk_i = ~clk_i;

  ipm_access u0 (.*);

  int n_chk = 0, n_bad = 0, n_wr_seen = 0, n_wr_exp = 0, cyc = 0;
  logic [16:0] exp_addr = '0;
  logic [7:0]  exp_hi = '0, exp_lo = '0;
  logic        exp_err = 1'b0;
  logic [1:0]  cur_op = '0;
  logic [15:0] ram_exp [int];
  logic [15:0] ram_mem [int];

  function automatic logic [15:0] ram_init(input logic [15:0] w);
    return (w * 16'h9E37) ^ 16'h1234;
  endfunction
  function automatic logic [15:0] flash_val(input logic [15:0] w);
    return ~(w * 16'h3B1D) ^ 16'h5A5A;
  endfunction
  function automatic logic [15:0] exp_read(input logic [16:0] b);
    logic [15:0] w = b[16:1];
    if (b < 17'h04000) return ram_exp.exists(int'(w)) ? ram_exp[int'(w)] : ram_init(w);
    return flash_val(w);
  endfunction
  function automatic logic [1:0] exp_rgn(input logic [16:0] b);
    if (b < 17'h04000) return 2'd0;
    if (b >= 17'h10000) return 2'd1;
    return 2'd2;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory responder, driven at negedges
  initial begin
    int wt = 0;
    forever begin
      @(negedge clk_i);
      if (mem_ready_i) begin
        mem_ready_i = 1'b0;
      end else if (mem_req_o) begin
        if (wt == 0) begin
          check("R3 word addr", 32'(mem_addr_o), 32'(exp_addr[16:1]));
          check("R6 region", 32'(mem_region_o), 32'(exp_rgn(exp_addr)));
          check("R4 write flag", 32'(mem_we_o), 32'(cur_op[1]));
          if (mem_we_o) begin
            n_wr_seen++;
            check("R4 write data", 32'(mem_wdata_o), {16'h0, exp_hi, exp_lo});
            ram_mem[int'(mem_addr_o)] = mem_wdata_o;
          end else if (mem_region_o == 2'd0) begin
            mem_rdata_i = ram_mem.exists(int'(mem_addr_o)) ? ram_mem[int'(mem_addr_o)]
                                                            : ram_init(mem_addr_o);
          end else begin
            mem_rdata_i = flash_val(mem_addr_o);
          end
          mem_ready_i = 1'b1;
          wt = $urandom % 4;
        end else begin
          wt--;
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 150000) begin
        n_bad++; n_chk++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end

  task automatic set_reg(input logic [2:0] sel, input logic [7:0] v);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_sel_i = sel; reg_wdata_i = v;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic get_reg(input logic [2:0] sel, output logic [7:0] v);
    reg_sel_i = sel;
    #0.5;
    v = reg_rdata_o;
  endtask

  task automatic set_addr(input logic [16:0] a);
    set_reg(3'd0, a[7:0]);
    set_reg(3'd1, a[15:8]);
    set_reg(3'd2, {7'b0, a[16]});
    exp_addr = a;
  endtask

  task automatic set_data(input logic [7:0] hi, input logic [7:0] lo);
    set_reg(3'd4, hi);
    set_reg(3'd3, lo);
    exp_hi = hi; exp_lo = lo;
  endtask

  task automatic check_state(input string req);
    logic [7:0] v;
    @(negedge clk_i);
    get_reg(3'd0, v); check({req, " addr lo"}, 32'(v), 32'(exp_addr[7:0]));
    get_reg(3'd1, v); check({req, " addr hi"}, 32'(v), 32'(exp_addr[15:8]));
    get_reg(3'd2, v); check({req, " addr ext"}, 32'(v), 32'(exp_addr[16]));
    get_reg(3'd3, v); check({req, " data lo"}, 32'(v), 32'(exp_lo));
    get_reg(3'd4, v); check({req, " data hi"}, 32'(v), 32'(exp_hi));
    get_reg(3'd5, v); check({req, " status"}, 32'(v), {30'b0, 1'b0, exp_err});
    check({req, " err_o"}, 32'(err_o), 32'(exp_err));
    check({req, " write count"}, 32'(n_wr_seen), 32'(n_wr_exp));
  endtask

  task automatic run_op(input logic [1:0] op, input bit poke);
    logic bad;
    logic [15:0] w;
    int guard = 0;
    bad = exp_addr[0] | (exp_rgn(exp_addr) == 2'd2) | (op[1] & (exp_rgn(exp_addr) != 2'd0));
    cur_op = op;
    @(negedge clk_i);
    op_valid_i = 1'b1; op_i = op;
    @(negedge clk_i);
    op_valid_i = 1'b0;
    if (bad) check("R7 refused not busy", 32'(busy_o), 32'd0);
    else     check("R8 busy after strobe", 32'(busy_o), 32'd1);
    if (poke && !bad) begin
      reg_we_i = 1'b1; reg_sel_i = 3'd0; reg_wdata_i = ~exp_addr[7:0];
      op_valid_i = 1'b1; op_i = 2'b11;
      @(negedge clk_i);
      reg_we_i = 1'b0; op_valid_i = 1'b0;
    end
    while (busy_o && guard < 64) begin
      @(negedge clk_i);
      guard++;
    end
    if (bad) begin
      exp_err = 1'b1;
    end else if (!op[1]) begin
      w = exp_read(exp_addr);
      exp_hi = w[15:8]; exp_lo = w[7:0];
    end else begin
      ram_exp[int'(exp_addr[16:1])] = {exp_hi, exp_lo};
      n_wr_exp++;
    end
    if (op[0]) exp_addr = exp_addr + 17'd2;
  endtask

  task automatic clear_err();
    set_reg(3'd5, 8'h00);
    exp_err = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h1D2C3B4A));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 mem_req", 32'(mem_req_o), 32'd0);
    check("R1 busy", 32'(busy_o), 32'd0);
    check_state("R1");

    set_addr(17'h1A5C4);
    set_data(8'hC3, 8'h3C);
    check_state("R2");

    // read program RAM
    set_addr(17'h00000);
    run_op(2'b00, 0); check_state("R3 read ram");
    // write top of RAM then read back
    set_addr(17'h03FFE);
    set_data(8'hBE, 8'hEF);
    run_op(2'b10, 0); check_state("R4 write");
    set_data(8'h00, 8'h00);
    run_op(2'b00, 0); check_state("R4 readback");
    // increment carry across byte boundaries
    set_addr(17'h000FE);
    set_data(8'h12, 8'h34);
    run_op(2'b11, 0); check_state("R5 carry lo");
    set_addr(17'h0FFFE);
    run_op(2'b01, 0); check_state("R5 carry ext");
    set_addr(17'h1FFFE);
    run_op(2'b01, 0); check_state("R5 wrap");
    // refusals
    set_addr(17'h00101);
    run_op(2'b01, 0); check_state("R7 misaligned");
    clear_err(); check_state("R9 clear");
    set_addr(17'h08000);
    run_op(2'b00, 0); check_state("R7 reserved");
    set_reg(3'd4, 8'h77); exp_hi = 8'h77;
    check_state("R9 sticky");
    clear_err();
    set_addr(17'h12000);
    run_op(2'b11, 0); check_state("R7 write flash");
    clear_err();
    // traffic while busy is dropped
    set_addr(17'h00200);
    run_op(2'b01, 1); check_state("R8 ignore busy");

    for (int i = 0; i < 300; i++) begin
      int r = $urandom % 16;
      if (($urandom % 2) == 0) begin
        if (r < 7)       set_addr({3'b0, 13'($urandom), 1'b0});
        else if (r < 13) set_addr({1'b1, 15'($urandom), 1'b0});
        else if (r < 15) set_addr(17'h04000 + {1'b0, 15'($urandom % 16'h6000), 1'b0});
        else             set_addr(17'($urandom) | 17'd1);
      end
      if (($urandom % 3) == 0) set_data(8'($urandom), 8'($urandom));
      run_op(2'($urandom), ($urandom % 5) == 0);
      check_state("R3 random");
      if (exp_err && ($urandom % 2) == 0) clear_err();
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule